// File: doc/BRIEF.md
# UART FIFO Watermark Interrupt Controller

This block holds the transmit and receive byte queues of a simple serial port and raises one level-sensitive interrupt. The interrupt comes from comparing each queue's live fill level with a programmable threshold. Software uses a small register bus. It writes outgoing bytes, up to four per access, and sets the two thresholds and the two interrupt enables. It reads the pending bits, the sticky overflow flag and incoming bytes. The serializer drains the transmit queue through a valid/ready byte handshake, and the deserializer fills the receive queue through a second handshake. Bit timing, baud generation and parity belong to the serializer and deserializer, outside this block.

The two directions use opposite strict comparisons. The transmit side asks for service while the queue is running low. The receive side asks for service once data piles up past its threshold. The transmit pending bit stays frozen for a programmable number of cycles after each transmit-queue push or pop, and only then takes up the new comparison.

Register select values on `bus_addr`: 0 transmit data, 1 receive data, 2 transmit threshold, 3 receive threshold, 4 enables, 5 pending, 6 overflow flag.

Top module: `uart_fifo_wm_irq`

## Requirements
- R1: After reset both queues are empty. The thresholds, enables and overflow flag read 0, `irq` is low, and `des_ready` is high.
- R2: Pending bit 0 (register 5) is 1 when the transmit queue holds fewer bytes than the transmit threshold in bits [2:0] of register 2. It follows a threshold change on the next clock. After a transmit-queue push or pop, it keeps its old value for TX_IRQ_DLY further clocks and then updates.
- R3: Pending bit 1 (register 5) is 1 as soon as the receive queue holds more bytes than the receive threshold in bits [2:0] of register 3.
- R4: `irq` is high exactly when (pending bit 0 and enable bit 0 of register 4) or (pending bit 1 and enable bit 1 of register 4).
- R5: A write to register 0 offers `bus_nbytes` bytes (clipped to 4) from the low lanes of `bus_wdata`, lane 0 first. If fewer slots are free, only that many leading bytes are queued, the rest are dropped, and overflow bit 0 of register 6 is set. An offer that fits exactly does not set it.
- R6: With the transmit queue full, a write offering bytes queues none of them and sets the overflow flag. A write offering zero bytes changes nothing.
- R7: Reading register 0 returns bit 31 = 1 exactly when the transmit queue holds 8 bytes, and returns the transmit fill level in bits [3:0].
- R8: Reading register 1 with data present returns the oldest byte in bits [7:0] with bit 31 = 0 and removes that byte. With the queue empty it returns bit 31 = 1 and leaves the queue unchanged.
- R9: The overflow flag stays set until a write to register 6 with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R10: `ser_valid` is high while the transmit queue is non-empty and presents bytes in the order they were queued, one removed per cycle with `ser_valid` and `ser_ready` both high. `des_ready` is low while the receive queue holds 8 bytes, and a byte offered then is dropped.
- R11: A transmit threshold of 0 never raises pending bit 0. A receive threshold of 7 raises pending bit 1 only when all 8 receive slots are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a receive-data read removes a byte |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data; four byte lanes for transmit writes |
| bus_nbytes | input | 3 | Number of bytes offered by a transmit-data write |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt |
| ser_valid | output | 1 | Transmit byte available |
| ser_byte | output | 8 | Oldest transmit byte |
| ser_ready | input | 1 | Serializer takes the byte |
| des_valid | input | 1 | Received byte offered |
| des_byte | input | 8 | Received byte |
| des_ready | output | 1 | Receive queue has room |

## Verification
The hardest state to reach from the ports is a partially full transmit queue hit by a multi-byte write that only partly fits. The transmit pending bit's frozen window after a queue event is similarly hard to reach. The bench holds `ser_ready` low so the queue only fills. It stacks writes of three and four bytes until one free slot is left, then offers three more. Draining then shows that exactly the first lane got in. For the window, the bench reads the pending register one clock after a four-byte push and again after the window has expired, so it sees both the held value and the updated value.

// File: rtl/sfifo_irq_pkg.sv
package sfifo_irq_pkg;

    typedef enum logic [2:0] {
        REG_TXDATA = 3'd0,
        REG_RXDATA = 3'd1,
        REG_TXWM   = 3'd2,
        REG_RXWM   = 3'd3,
        REG_IE     = 3'd4,
        REG_IP     = 3'd5,
        REG_ERR    = 3'd6
    } reg_sel_e;

    localparam int FLAG_BIT = 31;

endpackage

// File: rtl/sfifo_buf.sv
// Circular byte queue that accepts up to LANES bytes per cycle (clipped to free
// space) and releases at most one. DEPTH must be a power of two.
module sfifo_buf #(
    parameter  int DEPTH = 8,
    parameter  int W     = 8,
    parameter  int LANES = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        push_n,
    input  logic [LANES*W-1:0]   push_data,
    input  logic                 pop,
    output logic [W-1:0]         head,
    output logic [CW-1:0]        count,
    output logic [NW-1:0]        taken,
    output logic                 full,
    output logic                 empty
);

    localparam int SW = ((CW > NW) ? CW : NW) + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } buf_st_t;

    buf_st_t        st_d, st_q;
    logic [SW-1:0]  free_w, req_w, take_w;
    logic           popped;

    always_comb begin
        st_d   = st_q;
        free_w = SW'(DEPTH) - SW'(st_q.cnt);
        req_w  = SW'(push_n);
        take_w = (req_w > free_w) ? free_w : req_w;
        popped = pop && (st_q.cnt != '0);
        for (int i = 0; i < LANES; i++) begin
            if (SW'(i) < take_w) begin
                st_d.mem[st_q.wptr + AW'(i)] = push_data[i*W +: W];
            end
        end
        st_d.wptr = st_q.wptr + AW'(take_w);
        if (popped) begin
            st_d.rptr = st_q.rptr + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(take_w) - CW'(popped);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rptr];
    assign count = st_q.cnt;
    assign taken = NW'(take_w);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // Fill level never passes the queue size.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // A full queue without a removal keeps its oldest byte and stays full.
    assert_full_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(head)));

endmodule

// File: rtl/sfifo_wm_irq.sv
// Watermark comparison, transmit-side hold window and interrupt combine.
module sfifo_wm_irq #(
    parameter  int DEPTH = 8,
    parameter  int DLY   = 5,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int WMW   = $clog2(DEPTH),
    localparam int DW    = (DLY > 0) ? $clog2(DLY + 1) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  tx_count,
    input  logic [CW-1:0]  rx_count,
    input  logic [WMW-1:0] tx_mark,
    input  logic [WMW-1:0] rx_mark,
    input  logic           en_tx,
    input  logic           en_rx,
    input  logic           tx_event,
    output logic           tx_pend,
    output logic           rx_pend,
    output logic           irq
);

    typedef struct packed {
        logic [DW-1:0] dly;
        logic          tx_pend;
    } wm_st_t;

    wm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_event) begin
            st_d.dly = DW'(DLY);
        end else if (st_q.dly != '0) begin
            st_d.dly = st_q.dly - DW'(1);
        end else begin
            st_d.tx_pend = (tx_count < CW'(tx_mark));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_pend = st_q.tx_pend;
    assign rx_pend = (rx_count > CW'(rx_mark));
    assign irq     = (st_q.tx_pend & en_tx) | (rx_pend & en_rx);

    // While the hold window is open the transmit pending bit does not move.
    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dly != '0) |=> $stable(tx_pend));

endmodule

// File: rtl/uart_fifo_wm_irq.sv
module uart_fifo_wm_irq
    import sfifo_irq_pkg::*;
#(
    parameter  int DEPTH      = 8,
    parameter  int LANES      = 4,
    parameter  int TX_IRQ_DLY = 5,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int WMW        = $clog2(DEPTH),
    localparam int NW         = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [NW-1:0] bus_nbytes,
    output logic [31:0]   bus_rdata,
    output logic          irq,
    output logic          ser_valid,
    output logic [7:0]    ser_byte,
    input  logic          ser_ready,
    input  logic          des_valid,
    input  logic [7:0]    des_byte,
    output logic          des_ready
);

    typedef struct packed {
        logic [WMW-1:0] txmark;
        logic [WMW-1:0] rxmark;
        logic           en_tx;
        logic           en_rx;
        logic           ovf;
    } ctl_st_t;

    ctl_st_t        st_d, st_q;
    reg_sel_e       sel;
    logic [NW-1:0]  tx_req, tx_taken;
    logic [CW-1:0]  tx_count, rx_count;
    logic           tx_full, tx_empty, tx_pop;
    logic           rx_full, rx_empty, rx_pop;
    logic [7:0]     rx_head;
    logic [0:0]     rx_req, rx_taken;
    logic           tx_pend, rx_pend;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        tx_req = '0;
        if (bus_wr && sel == REG_TXDATA) begin
            tx_req = (bus_nbytes > NW'(LANES)) ? NW'(LANES) : bus_nbytes;
        end
    end

    assign tx_pop    = ser_valid && ser_ready;
    assign ser_valid = !tx_empty;
    assign rx_req    = 1'(des_valid && des_ready);
    assign des_ready = !rx_full;
    assign rx_pop    = bus_rd && sel == REG_RXDATA;

    sfifo_buf #(.DEPTH(DEPTH), .W(8), .LANES(LANES)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_req), .push_data(bus_wdata[LANES*8-1:0]), .pop(tx_pop),
        .head(ser_byte), .count(tx_count), .taken(tx_taken),
        .full(tx_full), .empty(tx_empty)
    );

    sfifo_buf #(.DEPTH(DEPTH), .W(8), .LANES(1)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_req), .push_data(des_byte), .pop(rx_pop),
        .head(rx_head), .count(rx_count), .taken(rx_taken),
        .full(rx_full), .empty(rx_empty)
    );

    sfifo_wm_irq #(.DEPTH(DEPTH), .DLY(TX_IRQ_DLY)) u_wm (
        .clk(clk), .rst_n(rst_n),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_mark(st_q.txmark), .rx_mark(st_q.rxmark),
        .en_tx(st_q.en_tx), .en_rx(st_q.en_rx),
        .tx_event((tx_taken != '0) || tx_pop),
        .tx_pend(tx_pend), .rx_pend(rx_pend), .irq(irq)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (sel)
                REG_TXWM: st_d.txmark = bus_wdata[WMW-1:0];
                REG_RXWM: st_d.rxmark = bus_wdata[WMW-1:0];
                REG_IE: begin
                    st_d.en_tx = bus_wdata[0];
                    st_d.en_rx = bus_wdata[1];
                end
                REG_ERR: if (bus_wdata[0]) st_d.ovf = 1'b0;
                default: ;
            endcase
        end
        if (tx_taken < tx_req) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                REG_TXDATA: begin
                    bus_rdata[FLAG_BIT] = tx_full;
                    bus_rdata[CW-1:0]   = tx_count;
                end
                REG_RXDATA: begin
                    if (rx_empty) bus_rdata[FLAG_BIT] = 1'b1;
                    else          bus_rdata[7:0]      = rx_head;
                end
                REG_TXWM: bus_rdata[WMW-1:0] = st_q.txmark;
                REG_RXWM: bus_rdata[WMW-1:0] = st_q.rxmark;
                REG_IE:   bus_rdata[1:0]     = {st_q.en_rx, st_q.en_tx};
                REG_IP:   bus_rdata[1:0]     = {rx_pend, tx_pend};
                REG_ERR:  bus_rdata[0]       = st_q.ovf;
                default:  ;
            endcase
        end
    end

    // An interrupt with the transmit enable off must come from receive fill.
    assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !st_q.en_tx) |-> (rx_count > CW'(st_q.rxmark)));

    // Overflow flag is only cleared by an explicit write of 1.
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !(bus_wr && sel == REG_ERR && bus_wdata[0])) |=> st_q.ovf);

    // A byte offered while ready is taken by the receive queue.
    assert_rx_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (des_valid && des_ready) |-> (rx_taken == 1'b1));

    // A stalled transmit byte stays presented unchanged.
    assert_ser_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_byte)));

endmodule

// File: tb/uart_fifo_wm_irq_tb.sv
module uart_fifo_wm_irq_tb;

    localparam int DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [2:0]  bus_nbytes;
    logic [31:0] bus_rdata;
    logic        irq, ser_valid, ser_ready, des_valid, des_ready;
    logic [7:0]  ser_byte, des_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    uart_fifo_wm_irq #(.TX_IRQ_DLY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_nbytes(bus_nbytes), .bus_rdata(bus_rdata),
        .irq(irq),
        .ser_valid(ser_valid), .ser_byte(ser_byte), .ser_ready(ser_ready),
        .des_valid(des_valid), .des_byte(des_byte), .des_ready(des_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [2:0] nb);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_nbytes = nb;
        @(negedge clk);
        bus_wr = 1'b0; bus_nbytes = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic des_push(input logic [7:0] b);
        @(negedge clk);
        des_valid = 1'b1; des_byte = b;
        @(negedge clk);
        des_valid = 1'b0;
    endtask

    task automatic drain(input logic [7:0] exp [], input string req);
        foreach (exp[k]) begin
            @(negedge clk);
            ser_ready = 1'b1;
            chk({req, " valid"}, 32'(ser_valid), 32'd1);
            chk({req, " byte"}, 32'(ser_byte), 32'(exp[k]));
        end
        @(negedge clk);
        ser_ready = 1'b0;
        chk({req, " empty"}, 32'(ser_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 des_ready", 32'(des_ready), 32'd1);
        rd_chk(3'd5, 32'h0, "R1 pending");
        rd_chk(3'd4, 32'h0, "R1 enables");
        rd_chk(3'd6, 32'h0, "R1 overflow");
        rd_chk(3'd2, 32'h0, "R1 tx threshold");
        rd_chk(3'd3, 32'h0, "R1 rx threshold");
        rd_chk(3'd0, 32'h0, "R1 tx level");
        rd_chk(3'd1, 32'h8000_0000, "R1 R8 rx empty");
    endtask

    task automatic t_tx_mark;
        wr(3'd2, 32'd3, 3'd0);
        idle(2);
        rd_chk(3'd5, 32'h1, "R2 pending low fill");
        chk("R4 irq gated off", 32'(irq), 32'd0);
        wr(3'd4, 32'h1, 3'd0);
        chk("R4 irq enabled", 32'(irq), 32'd1);
        wr(3'd0, 32'h4433_2211, 3'd4);
        rd_chk(3'd5, 32'h1, "R2 held in window");
        chk("R4 irq held", 32'(irq), 32'd1);
        idle(DLY + 2);
        rd_chk(3'd5, 32'h0, "R2 updated after window");
        chk("R4 irq dropped", 32'(irq), 32'd0);
        rd_chk(3'd0, 32'h4, "R7 level 4");
        wr(3'd0, 32'h8877_6655, 3'd4);
        rd_chk(3'd0, 32'h8000_0008, "R7 full flag");
        rd_chk(3'd6, 32'h0, "R5 exact fit no overflow");
        wr(3'd0, 32'hAABB_CCDD, 3'd3);
        rd_chk(3'd0, 32'h8000_0008, "R6 nothing pushed when full");
        rd_chk(3'd6, 32'h1, "R6 overflow set");
        drain('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88}, "R10 R6 drain order");
        idle(DLY + 2);
        rd_chk(3'd5, 32'h1, "R2 pending after drain");
        chk("R4 irq after drain", 32'(irq), 32'd1);
    endtask

    task automatic t_partial;
        wr(3'd6, 32'h0, 3'd0);
        rd_chk(3'd6, 32'h1, "R9 write 0 keeps flag");
        wr(3'd6, 32'h1, 3'd0);
        rd_chk(3'd6, 32'h0, "R9 write 1 clears");
        wr(3'd0, 32'h0000_00EE, 3'd0);
        rd_chk(3'd0, 32'h0, "R6 zero-byte write no push");
        rd_chk(3'd6, 32'h0, "R6 zero-byte write no flag");
        wr(3'd0, 32'h00A3_A2A1, 3'd3);
        wr(3'd0, 32'hB4B3_B2B1, 3'd4);
        rd_chk(3'd0, 32'h7, "R5 level 7");
        wr(3'd0, 32'h00C3_C2C1, 3'd3);
        rd_chk(3'd0, 32'h8000_0008, "R5 one byte accepted");
        rd_chk(3'd6, 32'h1, "R5 excess flagged");
        drain('{8'hA1, 8'hA2, 8'hA3, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hC1}, "R5 lane order");
        wr(3'd6, 32'h1, 3'd0);
    endtask

    task automatic t_rx;
        wr(3'd4, 32'h2, 3'd0);
        wr(3'd2, 32'd0, 3'd0);
        idle(DLY + 2);
        rd_chk(3'd5, 32'h0, "R11 tx threshold 0 quiet");
        wr(3'd3, 32'd2, 3'd0);
        des_push(8'h51);
        des_push(8'h52);
        rd_chk(3'd5, 32'h0, "R3 level equal threshold");
        chk("R4 irq rx quiet", 32'(irq), 32'd0);
        des_push(8'h53);
        rd_chk(3'd5, 32'h2, "R3 level above threshold");
        chk("R4 irq rx", 32'(irq), 32'd1);
        rd_chk(3'd1, 32'h51, "R8 oldest byte");
        rd_chk(3'd5, 32'h0, "R3 after removal");
        rd_chk(3'd1, 32'h52, "R8 second byte");
        rd_chk(3'd1, 32'h53, "R8 third byte");
        rd_chk(3'd1, 32'h8000_0000, "R8 empty flag");
        rd_chk(3'd1, 32'h8000_0000, "R8 empty read again");
        des_push(8'h60);
        rd_chk(3'd1, 32'h60, "R8 empty read kept level");
        wr(3'd3, 32'd7, 3'd0);
        for (int k = 0; k < 7; k++) des_push(8'h70 + 8'(k));
        rd_chk(3'd5, 32'h0, "R11 seven below max");
        des_push(8'h77);
        rd_chk(3'd5, 32'h2, "R11 full raises");
        chk("R4 irq full", 32'(irq), 32'd1);
        chk("R10 des_ready low", 32'(des_ready), 32'd0);
        des_push(8'h99);
        for (int k = 0; k < 8; k++) rd_chk(3'd1, 32'h70 + 32'(k), "R10 rx order");
        rd_chk(3'd1, 32'h8000_0000, "R10 offered byte dropped");
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; bus_nbytes = '0; ser_ready = 1'b0;
        des_valid = 1'b0; des_byte = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_tx_mark();
        t_partial();
        t_rx();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule